// File: doc/BRIEF.md
# Register File Writeback Bank Allocator

This block sits at the end of an execution pipeline and decides, in one combinational pass per cycle, which register-file banks receive write ports for a finished instruction. The instruction carries destination register numbers for its own (primary) warp and, optionally, destination lists of co-issued instruction sets that belong to other warps. Each destination is hashed onto a bank, and ports are claimed in a fixed order on banks that are idle this cycle.

If any required bank is already taken, the pass stops and the block asks the pipeline to present the same instruction again next cycle. Primary destinations that won a port are remembered so that a retry does not write them twice. Co-issued destinations are not remembered and are claimed again on every retry. On a completed writeback the block also reports a write-activity count for power accounting: either the number of active lanes or the full warp width.

Top module: `wb_bank_alloc`

## Requirements
- R1: Claims follow a fixed order: primary destinations by operand index, then set 0 destinations by operand index, then set 1, and so on. The first conflict ends the pass; banks granted before it keep their grant this cycle and nothing after it is granted.
- R2: A destination whose register field has its most significant bit set holds no register and requests no bank.
- R3: A co-issued set requests nothing when its valid bit is low, when its source-present bit is low, or when its warp id equals the primary warp id.
- R4: A destination whose bank is marked busy on `bank_busy_i` is never granted; it ends the pass, `wb_ok_o` goes low and `wb_stall_o` high. With `wb_valid_i` high exactly one of the two is high.
- R5: A bank granted earlier in the same pass counts as busy for later destinations, so two destinations that map to one bank cause a stall at the second.
- R6: A primary destination granted in a stalled pass is not requested again while the instruction is retried. Co-issued destinations are requested again on every retry.
- R7: The bank for a destination is `sched_i*(NUM_BANKS/NUM_SCHED) + (reg + warp) mod (NUM_BANKS/NUM_SCHED)`, where warp is the primary warp for primary destinations and the set's own warp for co-issued ones, and `sched_i` always comes from the primary instruction. A granted bank drives its register number (low REG_W-1 bits) on its slice of `bank_reg_o` and its warp on `bank_warp_o`; ungranted slices are zero.
- R8: When a writeback completes, `act_cnt_o` is the number of ones in `lane_mask_i` if `gate_en_i` is high, else WARP_SIZE. It is zero in any cycle without completion.
- R9: The memory of granted primary destinations is cleared after a completed writeback and after any cycle with `wb_valid_i` low.
- R10: After reset, and in any cycle with `wb_valid_i` low, no bank is written and both `wb_ok_o` and `wb_stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_valid_i | input | 1 | An instruction is presented for writeback |
| prim_warp_i | input | WID_W | Primary warp id |
| sched_i | input | SCHED_W | Scheduler id of the primary instruction |
| prim_dst_i | input | NUM_DST*REG_W | Primary destination registers, MSB set means none |
| set_valid_i | input | NUM_SETS | Co-issued set valid bits |
| set_has_src_i | input | NUM_SETS | Co-issued set has an attached source instruction |
| set_warp_i | input | NUM_SETS*WID_W | Warp id per co-issued set |
| set_dst_i | input | NUM_SETS*NUM_DST*REG_W | Destination registers per co-issued set |
| bank_busy_i | input | NUM_BANKS | Banks already in use this cycle |
| gate_en_i | input | 1 | Clock-gated register-file activity mode |
| lane_mask_i | input | WARP_SIZE | Active lanes of the primary instruction |
| wb_ok_o | output | 1 | All required banks granted, writeback done |
| wb_stall_o | output | 1 | A bank conflict occurred, retry next cycle |
| bank_we_o | output | NUM_BANKS | Write port granted per bank |
| bank_reg_o | output | NUM_BANKS*(REG_W-1) | Register number per granted bank |
| bank_warp_o | output | NUM_BANKS*WID_W | Warp id per granted bank |
| act_cnt_o | output | CNT_W | Write-activity count on completion |

## Verification
The only internal state is the mask of primary destinations already written. A bit stuck high would show in the very cycle of the next pass as a missing `bank_we_o` bit and an early `wb_ok_o`; a bit never set would show on the first retry as a repeated write on a bank that the retried pass then also contends for, possibly a stall where completion was expected. A wrong claim order or hash shows immediately on `bank_we_o`, `bank_reg_o` and `bank_warp_o` in the same cycle as the inputs.

// File: rtl/wb_alloc_pkg.sv
package wb_alloc_pkg;
  // sub-core bank hash: scheduler picks a bank group, reg+warp picks a bank within it
  function automatic int unsigned bank_of(int unsigned reg_num, int unsigned warp,
                                          int unsigned sched, int unsigned bps,
                                          int unsigned nb);
    return (sched * bps + (reg_num + warp) % bps) % nb;
  endfunction
endpackage

// File: rtl/wb_bank_map.sv
module wb_bank_map
  import wb_alloc_pkg::*;
#(
  parameter int NUM_OPS   = 6,
  parameter int VAL_W     = 7,
  parameter int WID_W     = 5,
  parameter int SCHED_W   = 1,
  parameter int NUM_BANKS = 8,
  parameter int NUM_SCHED = 2,
  parameter int BANK_W    = 3
) (
  input  logic [NUM_OPS*VAL_W-1:0]  op_num_i,
  input  logic [NUM_OPS*WID_W-1:0]  op_warp_i,
  input  logic [SCHED_W-1:0]        sched_i,
  output logic [NUM_OPS*BANK_W-1:0] op_bank_o
);
  localparam int BPS = NUM_BANKS / NUM_SCHED;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    assign op_bank_o[g*BANK_W +: BANK_W] =
      BANK_W'(bank_of(32'(op_num_i[g*VAL_W +: VAL_W]), 32'(op_warp_i[g*WID_W +: WID_W]),
                      32'(sched_i), BPS, NUM_BANKS));
  end
endmodule

// File: rtl/wb_claim_chain.sv
module wb_claim_chain #(
  parameter int NUM_OPS   = 6,
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input  logic [NUM_OPS-1:0]        op_req_i,
  input  logic [NUM_OPS*BANK_W-1:0] op_bank_i,
  input  logic [NUM_BANKS-1:0]      bank_busy_i,
  output logic [NUM_OPS-1:0]        op_grant_o,
  output logic                      pass_ok_o
);
  logic [NUM_BANKS-1:0] taken;
  logic                 stop;

  always_comb begin
    taken      = bank_busy_i;
    stop       = 1'b0;
    op_grant_o = '0;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (op_req_i[k] && !stop) begin
        if (taken[op_bank_i[k*BANK_W +: BANK_W]]) begin
          stop = 1'b1;
        end else begin
          taken[op_bank_i[k*BANK_W +: BANK_W]] = 1'b1;
          op_grant_o[k] = 1'b1;
        end
      end
    end
    pass_ok_o = !stop;
  end
endmodule

// File: rtl/wb_done_track.sv
module wb_done_track #(
  parameter int NUM_DST = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               ok_i,
  input  logic [NUM_DST-1:0] grant_i,
  output logic [NUM_DST-1:0] done_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                done_q_o <= '0;
    else if (!valid_i || ok_i)  done_q_o <= '0;
    else                        done_q_o <= done_q_o | grant_i;
  end
endmodule

// File: rtl/wb_bank_alloc.sv
module wb_bank_alloc #(
  parameter int NUM_BANKS = 8,
  parameter int NUM_SCHED = 2,
  parameter int NUM_DST   = 2,
  parameter int NUM_SETS  = 2,
  parameter int REG_W     = 8,
  parameter int WID_W     = 5,
  parameter int WARP_SIZE = 32,
  localparam int SCHED_W  = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1,
  localparam int CNT_W    = $clog2(WARP_SIZE + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wb_valid_i,
  input  logic [WID_W-1:0]                 prim_warp_i,
  input  logic [SCHED_W-1:0]               sched_i,
  input  logic [NUM_DST*REG_W-1:0]         prim_dst_i,
  input  logic [NUM_SETS-1:0]              set_valid_i,
  input  logic [NUM_SETS-1:0]              set_has_src_i,
  input  logic [NUM_SETS*WID_W-1:0]        set_warp_i,
  input  logic [NUM_SETS*NUM_DST*REG_W-1:0] set_dst_i,
  input  logic [NUM_BANKS-1:0]             bank_busy_i,
  input  logic                             gate_en_i,
  input  logic [WARP_SIZE-1:0]             lane_mask_i,
  output logic                             wb_ok_o,
  output logic                             wb_stall_o,
  output logic [NUM_BANKS-1:0]             bank_we_o,
  output logic [NUM_BANKS*(REG_W-1)-1:0]   bank_reg_o,
  output logic [NUM_BANKS*WID_W-1:0]       bank_warp_o,
  output logic [CNT_W-1:0]                 act_cnt_o
);
  localparam int VAL_W   = REG_W - 1;
  localparam int BANK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int NUM_OPS = NUM_DST * (1 + NUM_SETS);

  logic [NUM_OPS*VAL_W-1:0]  op_num;
  logic [NUM_OPS*WID_W-1:0]  op_warp;
  logic [NUM_OPS*BANK_W-1:0] op_bank;
  logic [NUM_OPS-1:0]        op_req;
  logic [NUM_OPS-1:0]        op_grant;
  logic [NUM_DST-1:0]        done_q;
  logic [NUM_SETS-1:0]       set_live;
  logic                      pass_ok;

  // primary operands occupy the first NUM_DST claim slots
  for (genvar p = 0; p < NUM_DST; p++) begin : g_prim
    assign op_num[p*VAL_W +: VAL_W]   = prim_dst_i[p*REG_W +: VAL_W];
    assign op_warp[p*WID_W +: WID_W]  = prim_warp_i;
    assign op_req[p] = wb_valid_i & ~prim_dst_i[p*REG_W + VAL_W] & ~done_q[p];
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    assign set_live[s] = set_valid_i[s] & set_has_src_i[s] &
                         (set_warp_i[s*WID_W +: WID_W] != prim_warp_i);
    for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
      localparam int K = NUM_DST + s*NUM_DST + d;
      localparam int F = (s*NUM_DST + d) * REG_W;
      assign op_num[K*VAL_W +: VAL_W]  = set_dst_i[F +: VAL_W];
      assign op_warp[K*WID_W +: WID_W] = set_warp_i[s*WID_W +: WID_W];
      assign op_req[K] = wb_valid_i & set_live[s] & ~set_dst_i[F + VAL_W];
    end
  end

  wb_bank_map #(
    .NUM_OPS(NUM_OPS), .VAL_W(VAL_W), .WID_W(WID_W), .SCHED_W(SCHED_W),
    .NUM_BANKS(NUM_BANKS), .NUM_SCHED(NUM_SCHED), .BANK_W(BANK_W)
  ) u_map (
    .op_num_i(op_num), .op_warp_i(op_warp), .sched_i(sched_i), .op_bank_o(op_bank)
  );

  wb_claim_chain #(
    .NUM_OPS(NUM_OPS), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) u_chain (
    .op_req_i(op_req), .op_bank_i(op_bank), .bank_busy_i(bank_busy_i),
    .op_grant_o(op_grant), .pass_ok_o(pass_ok)
  );

  wb_done_track #(.NUM_DST(NUM_DST)) u_done (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(wb_valid_i), .ok_i(wb_ok_o),
    .grant_i(op_grant[NUM_DST-1:0]), .done_q_o(done_q)
  );

  assign wb_ok_o    = wb_valid_i & pass_ok;
  assign wb_stall_o = wb_valid_i & ~pass_ok;

  // at most one granted op per bank, so a plain OR-steer is safe
  always_comb begin
    bank_we_o   = '0;
    bank_reg_o  = '0;
    bank_warp_o = '0;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (op_grant[k]) begin
        bank_we_o[op_bank[k*BANK_W +: BANK_W]] = 1'b1;
        bank_reg_o[32'(op_bank[k*BANK_W +: BANK_W])*VAL_W +: VAL_W] = op_num[k*VAL_W +: VAL_W];
        bank_warp_o[32'(op_bank[k*BANK_W +: BANK_W])*WID_W +: WID_W] = op_warp[k*WID_W +: WID_W];
      end
    end
  end

  logic [CNT_W-1:0] lane_cnt;
  always_comb begin
    lane_cnt = '0;
    for (int l = 0; l < WARP_SIZE; l++) lane_cnt = lane_cnt + CNT_W'(lane_mask_i[l]);
  end

  assign act_cnt_o = !wb_ok_o ? '0 : (gate_en_i ? lane_cnt : CNT_W'(WARP_SIZE));
endmodule

// File: rtl/wb_bank_alloc_chk.sv
module wb_bank_alloc_chk #(
  parameter int NUM_BANKS = 8,
  parameter int WARP_SIZE = 32,
  parameter int CNT_W     = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wb_valid_i,
  input logic [NUM_BANKS-1:0] bank_busy_i,
  input logic                 gate_en_i,
  input logic                 wb_ok_o,
  input logic                 wb_stall_o,
  input logic [NUM_BANKS-1:0] bank_we_o,
  input logic [CNT_W-1:0]     act_cnt_o
);
  AST_OK_STALL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |-> (wb_ok_o != wb_stall_o)); // R4

  AST_NO_GRANT_ON_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we_o & bank_busy_i) == '0); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_i |-> (bank_we_o == '0 && !wb_ok_o && !wb_stall_o)); // R10

  AST_ACT_ZERO_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_ok_o |-> act_cnt_o == '0); // R8

  AST_ACT_FULL_UNGATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_ok_o && !gate_en_i) |-> act_cnt_o == CNT_W'(WARP_SIZE)); // R8

  AST_ACT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_cnt_o <= CNT_W'(WARP_SIZE)); // R8
endmodule

bind wb_bank_alloc wb_bank_alloc_chk #(
  .NUM_BANKS(NUM_BANKS), .WARP_SIZE(WARP_SIZE), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wb_valid_i(wb_valid_i), .bank_busy_i(bank_busy_i),
  .gate_en_i(gate_en_i), .wb_ok_o(wb_ok_o), .wb_stall_o(wb_stall_o),
  .bank_we_o(bank_we_o), .act_cnt_o(act_cnt_o)
);

// File: tb/wb_bank_alloc_bench.sv
module wb_bank_alloc_bench;
  localparam int NB = 8, NSC = 2, ND = 2, NSET = 2, RW = 8, VW = 7, WW = 5, WS = 32;
  localparam int SW = 1, CW = 6, NOPS = ND * (1 + NSET), BPS = NB / NSC;
  localparam logic [RW-1:0] NONE = 8'h80;

  logic clk_i = 1'b0;
  logic rst_ni;
  always #4 clk_i = ~clk_i;

  logic              wb_valid;
  logic [WW-1:0]     pw;
  logic [SW-1:0]     sch;
  logic [RW-1:0]     pd [ND];
  logic [NSET-1:0]   sv, sh;
  logic [WW-1:0]     swp [NSET];
  logic [RW-1:0]     sd [NSET][ND];
  logic [NB-1:0]     busy;
  logic              gate;
  logic [WS-1:0]     lanes;

  logic [ND*RW-1:0]      pd_f;
  logic [NSET*WW-1:0]    swp_f;
  logic [NSET*ND*RW-1:0] sd_f;
  always_comb begin
    for (int i = 0; i < ND; i++) pd_f[i*RW +: RW] = pd[i];
    for (int s = 0; s < NSET; s++) begin
      swp_f[s*WW +: WW] = swp[s];
      for (int d = 0; d < ND; d++) sd_f[(s*ND+d)*RW +: RW] = sd[s][d];
    end
  end

  logic              ok, stall;
  logic [NB-1:0]     we;
  logic [NB*VW-1:0]  breg;
  logic [NB*WW-1:0]  bwarp;
  logic [CW-1:0]     act;

  wb_bank_alloc u_wb_bank_alloc (
    .clk_i(clk_i), .rst_ni(rst_ni), .wb_valid_i(wb_valid), .prim_warp_i(pw),
    .sched_i(sch), .prim_dst_i(pd_f), .set_valid_i(sv), .set_has_src_i(sh),
    .set_warp_i(swp_f), .set_dst_i(sd_f), .bank_busy_i(busy), .gate_en_i(gate),
    .lane_mask_i(lanes), .wb_ok_o(ok), .wb_stall_o(stall), .bank_we_o(we),
    .bank_reg_o(breg), .bank_warp_o(bwarp), .act_cnt_o(act)
  );

  int n_chk = 0, n_fail = 0;
  logic [ND-1:0]    done_m;
  logic             e_ok, e_stall;
  logic [NB-1:0]    e_we;
  logic [NB*VW-1:0] e_reg;
  logic [NB*WW-1:0] e_warp;
  logic [CW-1:0]    e_act;
  logic [ND-1:0]    e_pg;
  logic             s_ok, s_stall;
  logic [NB-1:0]    s_we;
  logic [NB*WW-1:0] s_warp;
  logic [CW-1:0]    s_act;

  task automatic chk(string tag, string what, longint a, longint e);
    n_chk++;
    if (a != e) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, a, e);
    end
  endtask

  function automatic int bmap(int r, int w, int s);
    return s * BPS + (r + w) % BPS;
  endfunction

  task automatic model();
    logic [NB-1:0] bz;
    bit ab;
    bz = busy; ab = 0;
    e_we = '0; e_reg = '0; e_warp = '0; e_pg = '0;
    for (int k = 0; k < NOPS; k++) begin
      logic [RW-1:0] r;
      logic [WW-1:0] w;
      bit req;
      if (k < ND) begin
        r = pd[k]; w = pw;
        req = wb_valid && !r[RW-1] && !done_m[k];
      end else begin
        int s, d;
        s = (k - ND) / ND; d = (k - ND) % ND;
        r = sd[s][d]; w = swp[s];
        req = wb_valid && sv[s] && sh[s] && (swp[s] != pw) && !r[RW-1];
      end
      if (req && !ab) begin
        int b;
        b = bmap(int'(r[VW-1:0]), int'(w), int'(sch));
        if (bz[b]) ab = 1;
        else begin
          bz[b] = 1'b1; e_we[b] = 1'b1;
          e_reg[b*VW +: VW] = r[VW-1:0];
          e_warp[b*WW +: WW] = w;
          if (k < ND) e_pg[k] = 1'b1;
        end
      end
    end
    e_ok = wb_valid && !ab;
    e_stall = wb_valid && ab;
    e_act = !e_ok ? '0 : (gate ? CW'($countones(lanes)) : CW'(WS));
  endtask

  task automatic cyc(string tag);
    @(negedge clk_i);
    model();
    chk(tag, "ok", ok, e_ok);
    chk(tag, "stall", stall, e_stall);
    chk(tag, "bank_we", we, e_we);
    chk(tag, "bank_reg", breg, e_reg);
    chk(tag, "bank_warp", bwarp, e_warp);
    chk(tag, "act_cnt", act, e_act);
    s_ok = ok; s_stall = stall; s_we = we; s_warp = bwarp; s_act = act;
    @(posedge clk_i);
    if (!wb_valid || e_ok) done_m = '0;
    else done_m = done_m | e_pg;
    #1;
  endtask

  task automatic idle_in();
    wb_valid = 0; pw = '0; sch = '0; sv = '0; sh = '0; busy = '0; gate = 0; lanes = '1;
    for (int i = 0; i < ND; i++) pd[i] = NONE;
    for (int s = 0; s < NSET; s++) begin
      swp[s] = '0;
      for (int d = 0; d < ND; d++) sd[s][d] = NONE;
    end
  endtask

  function automatic logic [RW-1:0] rnd_reg();
    return ($urandom % 4 == 0) ? NONE : RW'($urandom % 32);
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    done_m = '0;
    idle_in();
    rst_ni = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R10 reset / idle state
    cyc("R10");
    chk("R10", "we after reset", s_we, 0);
    chk("R10", "ok/stall after reset", {s_ok, s_stall}, 0);

    // R7 basic mapping: warp 3 sched 1, regs 5,6 -> banks 4,5
    wb_valid = 1; pw = 3; sch = 1; pd[0] = 5; pd[1] = 6;
    cyc("R7");
    chk("R7", "banks for regs 5,6", s_we, 8'h30);
    chk("R7", "ok", s_ok, 1);

    // R7 sched 0: warp 0 reg 2 -> bank 2, reg 6 -> bank 2 collides (R5)
    pw = 0; sch = 0; pd[0] = 2; pd[1] = NONE;
    cyc("R7");
    chk("R7", "sched 0 bank", s_we, 8'h04);
    pd[1] = 6;
    cyc("R5");
    chk("R5", "same-bank stall", {s_ok, s_stall}, 2'b01);
    chk("R5", "first of pair granted", s_we, 8'h04);
    wb_valid = 0; cyc("R9");

    // R4/R1/R6: busy on second bank, then retry
    wb_valid = 1; pw = 3; sch = 1; pd[0] = 5; pd[1] = 6; busy = 8'h20;
    cyc("R4");
    chk("R4", "stall on busy bank", {s_ok, s_stall}, 2'b01);
    chk("R1", "earlier grant kept", s_we, 8'h10);
    busy = 8'h00;
    cyc("R6");
    chk("R6", "retry writes only remaining", s_we, 8'h20);
    chk("R6", "retry completes", s_ok, 1);

    // R5 two primaries same bank: regs 5 and 9 -> bank 4
    pd[0] = 5; pd[1] = 9;
    cyc("R5");
    chk("R5", "stall", s_stall, 1);
    chk("R5", "grant first only", s_we, 8'h10);
    wb_valid = 0; cyc("R9");

    // R2/R7 co-issued set uses own warp: set0 warp 6 reg 1 -> bank 7
    wb_valid = 1; pd[0] = 5; pd[1] = NONE;
    sv = 2'b01; sh = 2'b01; swp[0] = 6; sd[0][0] = 1; sd[0][1] = NONE;
    cyc("R2");
    chk("R2", "negative regs skipped", s_we, 8'h90);
    chk("R7", "set warp on bank 7", s_warp[7*WW +: WW], 6);

    // R3 skip rules, each set0 reg 1 would hit bank 4 (warp 3) and stall
    swp[0] = 3;
    cyc("R3");
    chk("R3", "same warp skipped", {s_ok, s_we}, {1'b1, 8'h10});
    swp[0] = 7; sd[0][0] = 1; sh = 2'b00;
    cyc("R3");
    chk("R3", "no source skipped", {s_ok, s_we}, {1'b1, 8'h10});
    sh = 2'b01; sv = 2'b00;
    cyc("R3");
    chk("R3", "invalid set skipped", {s_ok, s_we}, {1'b1, 8'h10});

    // R6 co-issued re-requested: set0 warp 6 reg 1 -> bank 7 busy
    sv = 2'b01; sh = 2'b01; swp[0] = 6; busy = 8'h80;
    cyc("R6");
    chk("R6", "stall on set bank", {s_stall, s_we}, {1'b1, 8'h10});
    busy = 8'h00;
    cyc("R6");
    chk("R6", "set re-requested, primary not", {s_ok, s_we}, {1'b1, 8'h80});

    // R8 activity count
    sv = 2'b00; gate = 1; lanes = 32'h0000_00ff;
    cyc("R8");
    chk("R8", "gated count", s_act, 8);
    gate = 0;
    cyc("R8");
    chk("R8", "ungated count", s_act, 32);
    busy = 8'h10;
    cyc("R8");
    chk("R8", "no count on stall", s_act, 0);
    busy = 8'h00;

    // R9 memory cleared by a cycle without valid
    pd[0] = 5; pd[1] = 6; busy = 8'h20;
    cyc("R9");
    wb_valid = 0;
    cyc("R9");
    wb_valid = 1;
    cyc("R9");
    chk("R9", "primary granted again", s_we, 8'h10);
    busy = 8'h00;
    cyc("R9");

    // R1 constrained random with retries
    for (int it = 0; it < 600; it++) begin
      if ($urandom % 10 < 4) begin
        wb_valid = ($urandom % 8) != 0;
        pw = WW'($urandom % 8); sch = SW'($urandom % 2);
        for (int i = 0; i < ND; i++) pd[i] = rnd_reg();
        sv = NSET'($urandom); sh = NSET'($urandom);
        for (int s = 0; s < NSET; s++) begin
          swp[s] = WW'($urandom % 8);
          for (int d = 0; d < ND; d++) sd[s][d] = rnd_reg();
        end
        gate = $urandom % 2; lanes = $urandom;
      end
      busy = NB'($urandom & $urandom & $urandom);
      cyc("R1");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule